// File: doc/BRIEF.md
# Inbound Configuration-Space Address Translator

This block sits behind the inbound side of a serial fabric endpoint and turns each incoming request into a 33-bit local physical address. The address lands inside the device's configuration register region. The result can also be an error, or a plain "not for the configuration region" indication. The region starts at a 128 KB-aligned base, which is a 16-bit base register value followed by 17 zero bits. Two request families reach this region:

- Reads and writes-with-response that fall in the local configuration window.
- Maintenance requests, which carry their own configuration offset.

Plain writes and streaming writes that land in the local configuration window are illegal. The block rejects them and records them. Maintenance requests must be single aligned 32-bit accesses.

Every request produces exactly one registered result, one clock after its strobe. An error-capture log records the type and raw fabric address of the first rejected request. Any later rejection only raises an overflow flag. Software clears the log with a one-cycle clear pulse.

The log is a three-state machine:

- **LOG_EMPTY**: no error is recorded. The transition *first-error* moves to LOG_HELD.
- **LOG_HELD**: one error is recorded. The transition *repeat-error* moves to LOG_OVF. The transition *clear* moves to LOG_EMPTY. The transition *clear-and-capture* (clear and a new error in the same cycle) stays in LOG_HELD with the new error loaded.
- **LOG_OVF**: one error is recorded and at least one more has been seen since. The transitions *clear* and *clear-and-capture* leave it the same way as from LOG_HELD.

Top module: `cfg_xlate_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all result outputs and all log outputs are zero.
- R2: A request strobed in cycle t gives exactly one of `xl_valid`, `xl_err` or `xl_nohit` in cycle t+1. A cycle with no strobe gives none of the three in the next cycle. `xl_addr` is zero whenever `xl_valid` is low.
- R3: A read (kind 1) or write-with-response (kind 2) with `cfgwin_hit` high yields `xl_valid`. The address is `cfg_base`·2^17 + ((`req_addr` >> 3) mod 2^17), i.e. the base followed by `req_addr` bits 19..3.
- R4: When `genwin_hit` and `cfgwin_hit` are both high on a kind 1 or 2 request, the translation of R3 is still produced.
- R5: A write (kind 3) or streaming write (kind 4) with `cfgwin_hit` high yields `xl_err`, produces no address, and is logged.
- R6: A maintenance request (kind 0) yields `xl_valid` with address (((`cfg_base`·8 + `cfg_region`) mod 2^19)·2^14) + (`req_cfg_off` mod 2^13). In this address, bit 13 is always zero.
- R7: For maintenance, bits 20..13 of `req_cfg_off`, `cfgwin_hit` and `genwin_hit` have no effect on the result.
- R8: A maintenance request whose `req_size` is not code 2 (codes 0/1/2/3 mean 1/2/4/8 bytes), or whose `req_cfg_off` bits 1..0 are not zero, yields `xl_err` and is logged.
- R9: A kind 1–4 request without `cfgwin_hit`, and any request of reserved kind 5–7, yields `xl_nohit` only.
- R10: The first error sets `err_cap_valid` in the same cycle as its `xl_err`. `err_cap_kind` and `err_cap_addr` take that request's kind and raw fabric address and keep them until a clear.
- R11: An error arriving while the log holds an entry, with no clear in that cycle, sets `err_cap_ovf` and leaves the captured kind and address unchanged.
- R12: An `err_clr` pulse empties the log in the next cycle: valid, overflow, kind and address all become zero. If an error is strobed in the same cycle as the clear, the log instead holds that new error, with overflow low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 3 | 0 maintenance, 1 read, 2 write-with-response, 3 write, 4 streaming write, 5–7 reserved |
| req_addr | input | FAB_AW (34) | Fabric address of the request |
| req_cfg_off | input | OFF_W (21) | Maintenance configuration offset |
| req_size | input | 2 | Data size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| cfg_base | input | BASE_W (16) | Configuration region base register |
| cfg_region | input | REGION_W (5) | Strapped region offset for maintenance |
| cfgwin_hit | input | 1 | Request falls in the local configuration window |
| genwin_hit | input | 1 | Request falls in a general inbound window |
| err_clr | input | 1 | Write-one-to-clear pulse for the error log |
| xl_valid | output | 1 | Translated address is valid |
| xl_err | output | 1 | Request rejected |
| xl_nohit | output | 1 | Request not aimed at the configuration region |
| xl_addr | output | 33 | Translated local physical address |
| err_cap_valid | output | 1 | Log holds an error |
| err_cap_ovf | output | 1 | Further errors seen after the captured one |
| err_cap_kind | output | 3 | Kind of the captured request |
| err_cap_addr | output | FAB_AW (34) | Raw fabric address of the captured request |

## Verification
Two functions can meet in one cycle: a software clear of the error log, and the capture of a freshly rejected request. The bench provokes this in two ways. Directed steps pulse `err_clr` in the same cycle as a strobed illegal write. A long random phase also raises the clear now and then while errors are frequent. In every cycle, the behavioural model judges the log outputs by the rule that the new error is loaded and overflow drops. The second overlap is a rejection arriving while the log is already full. Here the captured kind and address must stay frozen while only overflow rises.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    typedef enum logic [2:0] {
        RK_MAINT  = 3'd0,
        RK_READ   = 3'd1,
        RK_WRRESP = 3'd2,
        RK_WRITE  = 3'd3,
        RK_STREAM = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_ADDR  = 2'd1,
        OUT_ERR   = 2'd2,
        OUT_NOHIT = 2'd3
    } xl_result_e;

    typedef enum logic [1:0] {
        WIN_CFG  = 2'd0,
        WIN_GEN  = 2'd1,
        WIN_NONE = 2'd2
    } win_sel_e;

    typedef enum logic [1:0] {
        LOG_EMPTY = 2'd0,
        LOG_HELD  = 2'd1,
        LOG_OVF   = 2'd2
    } log_state_e;

    localparam logic [1:0] SIZE_WORD = 2'd2;
    localparam int         WORD_LSB  = 2;

endpackage

// File: rtl/cfg_xlate_decode.sv
module cfg_xlate_decode
    import cfg_xlate_pkg::*;
#(
    parameter int FAB_AW   = 34,
    parameter int OFF_W    = 21,
    parameter int BASE_W   = 16,
    parameter int ALIGN_W  = 17,
    parameter int REGION_W = 5,
    parameter int IDX_W    = 13,
    parameter int SLICE_BE = 14
) (
    input  logic [2:0]                  kind,
    input  logic [FAB_AW-1:0]           fab_addr,
    input  logic [OFF_W-1:0]            cfg_off,
    input  logic [1:0]                  size,
    input  logic [BASE_W-1:0]           cfg_base,
    input  logic [REGION_W-1:0]         region,
    input  logic                        cfgwin_hit,
    input  logic                        genwin_hit,
    output xl_result_e                  result,
    output logic [BASE_W+ALIGN_W-1:0]   pa
);

    localparam int PA_W   = BASE_W + ALIGN_W;
    localparam int UP_W   = PA_W - IDX_W - 1;
    localparam int UP_PAD = UP_W - BASE_W;
    localparam int SL_HI  = FAB_AW - 1 - SLICE_BE;
    localparam int SL_LO  = SL_HI - ALIGN_W + 1;

    win_sel_e          win;
    logic [UP_W-1:0]   maint_up;
    logic [PA_W-1:0]   maint_pa;
    logic [PA_W-1:0]   win_pa;
    logic              maint_ok;
    logic              unused_off_hi;

    // the upper offset bits take no part in the maintenance index
    assign unused_off_hi = ^cfg_off[OFF_W-1:IDX_W];

    // configuration window outranks any general window
    always_comb begin
        if (cfgwin_hit)      win = WIN_CFG;
        else if (genwin_hit) win = WIN_GEN;
        else                 win = WIN_NONE;
    end

    assign maint_up = {cfg_base, {UP_PAD{1'b0}}} + UP_W'(region);
    assign maint_pa = {maint_up, 1'b0, cfg_off[IDX_W-1:0]};
    assign win_pa   = {cfg_base, fab_addr[SL_HI:SL_LO]};
    assign maint_ok = (size == SIZE_WORD) && (cfg_off[WORD_LSB-1:0] == '0);

    always_comb begin
        result = OUT_NOHIT;
        pa     = '0;
        case (kind)
            RK_MAINT: begin
                if (maint_ok) begin
                    result = OUT_ADDR;
                    pa     = maint_pa;
                end else begin
                    result = OUT_ERR;
                end
            end
            RK_READ, RK_WRRESP: begin
                if (win == WIN_CFG) begin
                    result = OUT_ADDR;
                    pa     = win_pa;
                end
            end
            RK_WRITE, RK_STREAM: begin
                if (win == WIN_CFG) result = OUT_ERR;
            end
            default: result = OUT_NOHIT;
        endcase
    end

endmodule

// File: rtl/cfg_xlate_errlog.sv
module cfg_xlate_errlog
    import cfg_xlate_pkg::*;
#(
    parameter int FAB_AW = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_in,
    input  logic [2:0]        err_kind,
    input  logic [FAB_AW-1:0] err_addr,
    input  logic              clr,
    output logic              cap_valid,
    output logic              cap_ovf,
    output logic [2:0]        cap_kind,
    output logic [FAB_AW-1:0] cap_addr
);

    log_state_e state_q, state_d;
    logic       load, wipe;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LOG_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOG_EMPTY: begin
                if (err_in) state_d = LOG_HELD;
            end
            LOG_HELD: begin
                if (clr)         state_d = err_in ? LOG_HELD : LOG_EMPTY;
                else if (err_in) state_d = LOG_OVF;
            end
            LOG_OVF: begin
                if (clr) state_d = err_in ? LOG_HELD : LOG_EMPTY;
            end
            default: state_d = LOG_EMPTY;
        endcase
    end

    assign load = err_in && (clr || state_q == LOG_EMPTY);
    assign wipe = clr && !err_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_kind <= '0;
            cap_addr <= '0;
        end else if (load) begin
            cap_kind <= err_kind;
            cap_addr <= err_addr;
        end else if (wipe) begin
            cap_kind <= '0;
            cap_addr <= '0;
        end
    end

    always_comb begin
        cap_valid = (state_q != LOG_EMPTY);
        cap_ovf   = (state_q == LOG_OVF);
    end

endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
    import cfg_xlate_pkg::*;
#(
    parameter int FAB_AW   = 34,
    parameter int OFF_W    = 21,
    parameter int BASE_W   = 16,
    parameter int ALIGN_W  = 17,
    parameter int REGION_W = 5,
    parameter int IDX_W    = 13,
    parameter int SLICE_BE = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [2:0]                  req_kind,
    input  logic [FAB_AW-1:0]           req_addr,
    input  logic [OFF_W-1:0]            req_cfg_off,
    input  logic [1:0]                  req_size,
    input  logic [BASE_W-1:0]           cfg_base,
    input  logic [REGION_W-1:0]         cfg_region,
    input  logic                        cfgwin_hit,
    input  logic                        genwin_hit,
    input  logic                        err_clr,
    output logic                        xl_valid,
    output logic                        xl_err,
    output logic                        xl_nohit,
    output logic [BASE_W+ALIGN_W-1:0]   xl_addr,
    output logic                        err_cap_valid,
    output logic                        err_cap_ovf,
    output logic [2:0]                  err_cap_kind,
    output logic [FAB_AW-1:0]           err_cap_addr
);

    localparam int PA_W = BASE_W + ALIGN_W;

    xl_result_e       dec_res, res_q;
    logic [PA_W-1:0]  dec_pa, addr_q;
    logic             dec_err;

    cfg_xlate_decode #(
        .FAB_AW(FAB_AW), .OFF_W(OFF_W), .BASE_W(BASE_W), .ALIGN_W(ALIGN_W),
        .REGION_W(REGION_W), .IDX_W(IDX_W), .SLICE_BE(SLICE_BE)
    ) u_decode (
        .kind       (req_kind),
        .fab_addr   (req_addr),
        .cfg_off    (req_cfg_off),
        .size       (req_size),
        .cfg_base   (cfg_base),
        .region     (cfg_region),
        .cfgwin_hit (cfgwin_hit),
        .genwin_hit (genwin_hit),
        .result     (dec_res),
        .pa         (dec_pa)
    );

    assign dec_err = req_valid && (dec_res == OUT_ERR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= OUT_NONE;
            addr_q <= '0;
        end else if (req_valid) begin
            res_q  <= dec_res;
            addr_q <= (dec_res == OUT_ADDR) ? dec_pa : '0;
        end else begin
            res_q  <= OUT_NONE;
            addr_q <= '0;
        end
    end

    always_comb begin
        xl_valid = (res_q == OUT_ADDR);
        xl_err   = (res_q == OUT_ERR);
        xl_nohit = (res_q == OUT_NOHIT);
        xl_addr  = addr_q;
    end

    cfg_xlate_errlog #(.FAB_AW(FAB_AW)) u_errlog (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_in    (dec_err),
        .err_kind  (req_kind),
        .err_addr  (req_addr),
        .clr       (err_clr),
        .cap_valid (err_cap_valid),
        .cap_ovf   (err_cap_ovf),
        .cap_kind  (err_cap_kind),
        .cap_addr  (err_cap_addr)
    );

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
    parameter int FAB_AW   = 34,
    parameter int BASE_W   = 16,
    parameter int ALIGN_W  = 17,
    parameter int SLICE_BE = 14
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic [2:0]                req_kind,
    input logic [FAB_AW-1:0]         req_addr,
    input logic [BASE_W-1:0]         cfg_base,
    input logic                      cfgwin_hit,
    input logic                      err_clr,
    input logic                      xl_valid,
    input logic                      xl_err,
    input logic                      xl_nohit,
    input logic [BASE_W+ALIGN_W-1:0] xl_addr,
    input logic                      err_cap_valid,
    input logic                      err_cap_ovf,
    input logic [2:0]                err_cap_kind,
    input logic [FAB_AW-1:0]         err_cap_addr
);

    localparam int SL_HI = FAB_AW - 1 - SLICE_BE;
    localparam int SL_LO = SL_HI - ALIGN_W + 1;

    // R2
    single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xl_valid, xl_err, xl_nohit}));

    // R2
    req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (xl_valid || xl_err || xl_nohit));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(xl_valid || xl_err || xl_nohit) && (xl_addr == '0));

    // R4
    cfgwin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 3'd1 || req_kind == 3'd2) && cfgwin_hit)
        |=> xl_valid && (xl_addr == {$past(cfg_base), $past(req_addr[SL_HI:SL_LO])}));

    // R5
    cfgwin_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 3'd3 || req_kind == 3'd4) && cfgwin_hit) |=> xl_err);

    // R10
    first_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_err && !$past(err_cap_valid)) |->
        err_cap_valid && (err_cap_addr == $past(req_addr)) && (err_cap_kind == $past(req_kind)));

    // R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cap_valid && !err_clr) |=>
        err_cap_valid && $stable(err_cap_addr) && $stable(err_cap_kind));

    // R11
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_err && $past(err_cap_valid) && !$past(err_clr)) |-> err_cap_ovf);

    // R12
    clr_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !err_cap_ovf);

endmodule

bind cfg_xlate_top cfg_xlate_chk #(
    .FAB_AW(FAB_AW), .BASE_W(BASE_W), .ALIGN_W(ALIGN_W), .SLICE_BE(SLICE_BE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_addr      (req_addr),
    .cfg_base      (cfg_base),
    .cfgwin_hit    (cfgwin_hit),
    .err_clr       (err_clr),
    .xl_valid      (xl_valid),
    .xl_err        (xl_err),
    .xl_nohit      (xl_nohit),
    .xl_addr       (xl_addr),
    .err_cap_valid (err_cap_valid),
    .err_cap_ovf   (err_cap_ovf),
    .err_cap_kind  (err_cap_kind),
    .err_cap_addr  (err_cap_addr)
);

// File: tb/cfg_xlate_top_tb.sv
`timescale 1ns/100ps
module cfg_xlate_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [33:0] req_addr = '0;
    logic [20:0] req_cfg_off = '0;
    logic [1:0]  req_size = '0;
    logic [15:0] cfg_base = '0;
    logic [4:0]  cfg_region = '0;
    logic        cfgwin_hit = 1'b0;
    logic        genwin_hit = 1'b0;
    logic        err_clr = 1'b0;
    logic        xl_valid, xl_err, xl_nohit;
    logic [32:0] xl_addr;
    logic        err_cap_valid, err_cap_ovf;
    logic [2:0]  err_cap_kind;
    logic [33:0] err_cap_addr;

    always #2.5 clk = ~clk;

    cfg_xlate_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_cfg_off(req_cfg_off), .req_size(req_size),
        .cfg_base(cfg_base), .cfg_region(cfg_region), .cfgwin_hit(cfgwin_hit),
        .genwin_hit(genwin_hit), .err_clr(err_clr), .xl_valid(xl_valid),
        .xl_err(xl_err), .xl_nohit(xl_nohit), .xl_addr(xl_addr),
        .err_cap_valid(err_cap_valid), .err_cap_ovf(err_cap_ovf),
        .err_cap_kind(err_cap_kind), .err_cap_addr(err_cap_addr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    bit          m_cv, m_ovf;
    logic [2:0]  m_kind;
    logic [33:0] m_addr;
    bit          e_v, e_e, e_n;
    logic [32:0] e_pa;

    task automatic compare(input string tag);
        n_chk++;
        if ({xl_valid, xl_err, xl_nohit} !== {e_v, e_e, e_n} || xl_addr !== e_pa ||
            err_cap_valid !== m_cv || err_cap_ovf !== m_ovf ||
            err_cap_kind !== m_kind || err_cap_addr !== m_addr) begin
            n_fail++;
            $display("FAIL %s: got v/e/n=%b%b%b addr=%h log=%b%b k%0d a=%h exp v/e/n=%b%b%b addr=%h log=%b%b k%0d a=%h",
                     tag, xl_valid, xl_err, xl_nohit, xl_addr, err_cap_valid, err_cap_ovf,
                     err_cap_kind, err_cap_addr, e_v, e_e, e_n, e_pa, m_cv, m_ovf, m_kind, m_addr);
        end
    endtask

    task automatic step(input bit v, input logic [2:0] k, input logic [33:0] a,
                        input logic [20:0] o, input logic [1:0] sz, input bit cw,
                        input bit gw, input bit clr, input string tag);
        longint pa;
        bit     err;
        req_valid = v; req_kind = k; req_addr = a; req_cfg_off = o;
        req_size = sz; cfgwin_hit = cw; genwin_hit = gw; err_clr = clr;
        e_v = 0; e_e = 0; e_n = 0; pa = 0;
        if (v) begin
            if (k == 3'd0) begin
                if (sz == 2'd2 && (o % 4) == 0) begin
                    e_v = 1;
                    pa = ((longint'(cfg_base) * 8 + longint'(cfg_region)) % (64'd1 << 19)) * 16384
                         + (longint'(o) % 8192);
                end else e_e = 1;
            end else if ((k == 3'd1 || k == 3'd2) && cw) begin
                e_v = 1;
                pa = longint'(cfg_base) * 131072 + ((longint'(a) >> 3) % 131072);
            end else if ((k == 3'd3 || k == 3'd4) && cw) e_e = 1;
            else e_n = 1;
        end
        e_pa = pa[32:0];
        err = e_e;
        if (clr) begin
            if (err) begin m_cv = 1; m_ovf = 0; m_kind = k; m_addr = a; end
            else     begin m_cv = 0; m_ovf = 0; m_kind = 0; m_addr = 0; end
        end else if (err) begin
            if (!m_cv) begin m_cv = 1; m_kind = k; m_addr = a; end
            else m_ovf = 1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got no completion exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m_cv = 0; m_ovf = 0; m_kind = 0; m_addr = 0;
        e_v = 0; e_e = 0; e_n = 0; e_pa = 0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        cfg_base = 16'hA5C3; cfg_region = 5'd7;
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1 after reset");
        step(0, 1, 34'h3_FFFF_FFFF, 0, 2, 1, 1, 0, "R2 no strobe");
        // R3 reads and write-with-response in config window
        step(1, 1, 34'h0_000F_FFF8, 0, 2, 1, 0, 0, "R3 read slice all ones");
        step(1, 2, 34'h2_1234_5677, 0, 0, 1, 0, 0, "R3 wr-resp");
        step(1, 1, 34'h0_0000_0000, 0, 3, 1, 0, 0, "R3 zero addr");
        // R4 both windows
        step(1, 1, 34'h1_ABCD_EF08, 0, 2, 1, 1, 0, "R4 read both windows");
        step(1, 2, 34'h3_0008_0010, 0, 2, 1, 1, 0, "R4 wr-resp both windows");
        // R5 illegal writes, R10 capture, R11 overflow
        step(1, 3, 34'h1_0000_0040, 0, 2, 1, 0, 0, "R5 R10 write in config window");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10 log held");
        step(1, 4, 34'h2_2222_2220, 0, 2, 1, 1, 0, "R5 R11 stream write overflow");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11 log still held");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R12 clear");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R12 log empty");
        // R6 maintenance
        step(1, 0, 34'h1_1111_1111, 21'h001FFC, 2, 0, 0, 0, "R6 maint max index");
        cfg_base = 16'hFFFF; cfg_region = 5'd31;
        step(1, 0, 0, 21'h000104, 2, 0, 0, 0, "R6 maint upper carry");
        cfg_base = 16'h0000; cfg_region = 5'd0;
        step(1, 0, 0, 21'h000000, 2, 0, 0, 0, "R6 maint zero");
        cfg_base = 16'h1234; cfg_region = 5'd19;
        step(1, 0, 0, 21'h1FE008, 2, 1, 1, 0, "R7 maint high offset bits windows set");
        step(1, 0, 0, 21'h0AA008, 2, 0, 1, 0, "R7 maint other high bits");
        // R8 maintenance errors
        step(1, 0, 34'h0_0000_0ABC, 21'h000010, 3, 0, 0, 0, "R8 maint 8B size");
        step(1, 0, 34'h0_0000_0DEF, 21'h000012, 2, 0, 0, 0, "R8 R11 maint misaligned");
        step(1, 0, 0, 21'h000011, 1, 0, 0, 0, "R8 maint 2B odd");
        // R12 clear with simultaneous error
        step(1, 3, 34'h3_CAFE_0000, 0, 2, 1, 0, 1, "R12 clear and capture");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R12 after clear and capture");
        step(1, 4, 34'h0_0000_1000, 0, 2, 1, 0, 0, "R11 ovf after reload");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R12 clear from overflow");
        // R9 no hit
        step(1, 1, 34'h1_0000_0000, 0, 2, 0, 1, 0, "R9 read general window only");
        step(1, 3, 34'h1_0000_0000, 0, 2, 0, 0, 0, "R9 write no window");
        step(1, 6, 34'h1_0000_0000, 0, 2, 1, 1, 0, "R9 reserved kind");
        step(1, 5, 34'h0, 21'h0, 2, 1, 0, 0, "R9 reserved kind 5");
        // random phase
        for (int i = 0; i < 600; i++) begin
            cfg_base = 16'($urandom);
            cfg_region = 5'($urandom);
            step(($urandom % 4) != 0, 3'($urandom_range(0, 7)),
                 {2'($urandom), 32'($urandom)}, 21'($urandom) & 21'h1FFFFC | 21'($urandom % 2),
                 2'($urandom_range(1, 3)), ($urandom % 3) != 0, ($urandom % 2) != 0,
                 ($urandom % 7) == 0, "R2 R12 random");
        end
        req_valid = 0; err_clr = 0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule